// File: doc/BRIEF.md
# No-Load Gated Energy Integrator

This block adds a per-sample magnitude into a running energy register. A sample is added only when its magnitude is at or above a selectable creep threshold. Meters use it to keep tiny residual readings from building up as phantom consumption when no load is connected. A source-select input picks the integrand. One choice is the apparent-power magnitude. The other is the RMS current magnitude, which gives ampere-hour integration when no voltage is present. The same threshold gate applies to whichever source is chosen.

A sample below the threshold is dropped. It also sets a sticky no-load flag. The interrupt output is the flag masked by an enable input. A write-one-to-clear pulse drops the flag. If the condition continues, the next below-threshold sample sets the flag again.

Full scale is a parameter. The three thresholds are computed from it as integer fractions, and each one is half the one before.

Top module: `nl_energy_gate`

## Requirements
- R1: After reset the energy register, the no-load flag and the interrupt output are all 0.
- R2: On a cycle with `smp_vld` high and the sample not gated, the energy register increases by the selected magnitude. The new value is visible after that clock edge. With `smp_vld` low the energy register holds its value.
- R3: With `thr_sel` = 2'b00 the gate is off. Every strobed sample is added, including a magnitude of 0, and the no-load flag is never set.
- R4: Codes 2'b01, 2'b10 and 2'b11 select the thresholds floor(FULL_SCALE*3/10000), floor(FULL_SCALE*3/20000) and floor(FULL_SCALE*3/40000). For the default FULL_SCALE of 16777215 these are 5033, 2516 and 1258. A magnitude strictly below the selected threshold is not added. A magnitude equal to the threshold is added.
- R5: A strobed sample below the selected threshold sets `nl_flag` after that clock edge.
- R6: `irq` is high exactly when `nl_flag` is high and `nl_ien` is high.
- R7: `nl_flag` stays set through later samples that are above the threshold. A `nl_clr` pulse clears it after the next edge. If a below-threshold sample is strobed in the same cycle as `nl_clr`, the flag stays set.
- R8: With `src_sel` = 1 the integrand and the threshold comparison use `irms_mag`. With `src_sel` = 0 they use `pwr_mag`. Switching `src_sel` affects only the next strobed sample and does not reset the energy register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_mag | input | MAG_W | Unsigned apparent-power magnitude |
| irms_mag | input | MAG_W | Unsigned RMS current magnitude |
| smp_vld | input | 1 | Sample strobe |
| thr_sel | input | 2 | Threshold code: 00 off, 01/10/11 thresholds that halve at each step |
| src_sel | input | 1 | Integrand select: 0 power, 1 current |
| nl_ien | input | 1 | Interrupt enable for the no-load flag |
| nl_clr | input | 1 | Write-one-to-clear pulse for the flag |
| energy | output | ACC_W | Running energy register |
| nl_flag | output | 1 | Sticky no-load status |
| irq | output | 1 | Interrupt request |

## Verification
The energy register and the no-load flag are registered. Each one reflects a strobed sample or a clear pulse one clock edge after that sample or pulse is applied. The interrupt is combinational from the flag and the enable, so it shows a change in `nl_ien` in the same cycle. The bench drives inputs on the falling edge and samples on the next falling edge, after exactly one rising edge. For the interrupt it samples after a short settle delay with no edge in between. Each table vector is followed by a separate clear cycle, so the result of every sample is seen on its own before the next stimulus.

// File: rtl/nl_energy_gate.sv
module nl_energy_gate #(
  parameter int MAG_W = 24,
  parameter int ACC_W = 40,
  parameter longint unsigned FULL_SCALE = 64'd16777215
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W-1:0] pwr_mag,
  input  logic [MAG_W-1:0] irms_mag,
  input  logic             smp_vld,
  input  logic [1:0]       thr_sel,
  input  logic             src_sel,
  input  logic             nl_ien,
  input  logic             nl_clr,
  output logic [ACC_W-1:0] energy,
  output logic             nl_flag,
  output logic             irq
);
  localparam longint unsigned TH_HI  = (FULL_SCALE * 3) / 10000;
  localparam longint unsigned TH_MID = (FULL_SCALE * 3) / 20000;
  localparam longint unsigned TH_LO  = (FULL_SCALE * 3) / 40000;

  logic [MAG_W-1:0] mag;
  logic [63:0]      thr;
  logic             below;

  assign mag = src_sel ? irms_mag : pwr_mag;

  always_comb begin
    case (thr_sel)
      2'b01:   thr = TH_HI;
      2'b10:   thr = TH_MID;
      2'b11:   thr = TH_LO;
      default: thr = '0;
    endcase
  end

  assign below = (thr_sel != 2'b00) && (64'(mag) < thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      energy  <= '0;
      nl_flag <= 1'b0;
    end else begin
      if (smp_vld && !below)
        energy <= energy + ACC_W'(mag);
      if (smp_vld && below)
        nl_flag <= 1'b1;
      else if (nl_clr)
        nl_flag <= 1'b0;
    end
  end

  assign irq = nl_flag & nl_ien;

  // R2
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> energy == $past(energy));

  // R3
  gate_off_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && thr_sel == 2'b00) |=> energy == $past(energy) + ACC_W'($past(mag)));

  // R4
  top_thr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && thr_sel == 2'b01 && 64'(mag) < TH_HI) |=> energy == $past(energy));

  // R5
  flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && thr_sel == 2'b11 && 64'(mag) < TH_LO) |=> nl_flag);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_flag && !nl_clr) |=> nl_flag);

  // R7
  flag_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nl_clr && !smp_vld) |=> !nl_flag);

  // R6
  always_comb irq_mask_chk: assert (irq == (nl_flag && nl_ien));
endmodule

// File: tb/sim_nl_energy_gate.sv
module sim_nl_energy_gate;
  localparam int MAG_W = 24;
  localparam int ACC_W = 40;
  localparam int NV = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [MAG_W-1:0] pwr_mag = '0;
  logic [MAG_W-1:0] irms_mag = '0;
  logic             smp_vld = 1'b0;
  logic [1:0]       thr_sel = 2'b00;
  logic             src_sel = 1'b0;
  logic             nl_ien = 1'b0;
  logic             nl_clr = 1'b0;
  logic [ACC_W-1:0] energy;
  logic             nl_flag;
  logic             irq;

  int checks = 0;
  int fails = 0;
  logic [ACC_W-1:0] model = '0;

  always #10 clk = ~clk;

  nl_energy_gate u0 (.*);

  // {thr, src, pwr, irms, add, below}
  typedef struct packed {
    logic [1:0]  thr;
    logic        src;
    logic [23:0] pwr;
    logic [23:0] irms;
    logic [23:0] add;
    logic        blw;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{2'b00, 1'b0, 24'd0,       24'd999,  24'd0,    1'b0},  // R3 zero still adds
    '{2'b00, 1'b0, 24'd100,     24'd0,    24'd100,  1'b0},  // R3
    '{2'b01, 1'b0, 24'd5032,    24'd0,    24'd0,    1'b1},  // R4 below 5033
    '{2'b01, 1'b0, 24'd5033,    24'd0,    24'd5033, 1'b0},  // R4 equal
    '{2'b10, 1'b0, 24'd2515,    24'd0,    24'd0,    1'b1},  // R4
    '{2'b10, 1'b0, 24'd2516,    24'd0,    24'd2516, 1'b0},  // R4
    '{2'b11, 1'b0, 24'd1257,    24'd0,    24'd0,    1'b1},  // R4
    '{2'b11, 1'b0, 24'd1258,    24'd0,    24'd1258, 1'b0},  // R4
    '{2'b11, 1'b1, 24'd9000000, 24'd1257, 24'd0,    1'b1},  // R8 current gated
    '{2'b11, 1'b1, 24'd0,       24'd4000, 24'd4000, 1'b0},  // R8
    '{2'b01, 1'b1, 24'd4000,    24'd6000, 24'd6000, 1'b0}   // R8
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    smp_vld = 1'b0;
    nl_clr  = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc();
    cyc();
    chk(energy == 0, "R1 energy", energy, 0);
    chk(nl_flag == 0, "R1 flag", nl_flag, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    rst_n = 1'b1;
    cyc();

    for (int i = 0; i < NV; i++) begin
      thr_sel = VT[i].thr; src_sel = VT[i].src;
      pwr_mag = VT[i].pwr; irms_mag = VT[i].irms;
      smp_vld = 1'b1;
      cyc();
      model = model + ACC_W'(VT[i].add);
      chk(energy == model, "R2/R4/R8 energy", energy, model);
      chk(nl_flag == VT[i].blw, "R5 flag", nl_flag, VT[i].blw);
      nl_clr = 1'b1;
      cyc();
      chk(nl_flag == 0, "R7 clear", nl_flag, 0);
    end

    // R2 no strobe holds
    pwr_mag = 24'd777; thr_sel = 2'b00; src_sel = 1'b0;
    cyc(); cyc();
    chk(energy == model, "R2 hold", energy, model);

    // R5/R6/R7 sticky flag, irq masking, set beats clear
    thr_sel = 2'b01; pwr_mag = 24'd10; smp_vld = 1'b1;
    cyc();
    chk(nl_flag == 1, "R5 set", nl_flag, 1);
    #1 chk(irq == 0, "R6 masked", irq, 0);
    nl_ien = 1'b1;
    #1 chk(irq == 1, "R6 enabled", irq, 1);
    pwr_mag = 24'd8000; smp_vld = 1'b1;
    cyc();
    model = model + 40'd8000;
    chk(nl_flag == 1, "R7 sticky", nl_flag, 1);
    chk(energy == model, "R2 add", energy, model);
    pwr_mag = 24'd5; smp_vld = 1'b1; nl_clr = 1'b1;
    cyc();
    chk(nl_flag == 1, "R7 set wins", nl_flag, 1);
    nl_clr = 1'b1;
    cyc();
    chk(nl_flag == 0, "R7 cleared", nl_flag, 0);
    #1 chk(irq == 0, "R6 follows flag", irq, 0);

    // R8 switching source keeps energy, takes effect on next strobe
    src_sel = 1'b1; irms_mag = 24'd3;
    cyc();
    chk(energy == model, "R8 switch keeps energy", energy, model);
    thr_sel = 2'b00; smp_vld = 1'b1;
    cyc();
    model = model + 40'd3;
    chk(energy == model, "R8 current added", energy, model);

    // R1 reset mid-run
    rst_n = 1'b0;
    cyc();
    chk(energy == 0, "R1 re-reset", energy, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule